// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in front of the ALU of a 16-bit pipeline whose execute stage is followed by two memory stages (M1, M2) and a writeback stage. For each of the two source operands of the instruction in execute, it compares the source register number with the destination numbers of the three younger stages. It then picks where the operand comes from: the register file, one of the three stages, or, for operand B, the immediate. It drives the matching select code and the chosen 16-bit operand value.

When a source needs the result of a load that is still in M1 or M2, the data cannot be forwarded yet, so the unit raises a load-use stall request. While the pipeline is stalled, writeback keeps moving. A per-operand hold register therefore keeps a value that was forwarded from writeback, so execute still sees it when the stall ends.

Top module: `pipe_fwd_unit`

## Requirements
- R1: `sel_a` is 2'b00 for the register file, 2'b01 for M1, 2'b10 for M2 and 2'b11 for writeback. When several stages match, the youngest wins: M1 over M2, and M2 over writeback.
- R2: `sel_b` is 3'b001 for the immediate, 3'b010 for M1, 3'b011 for M2, 3'b100 for writeback and 3'b000 for the register file. `use_imm` high forces 3'b001, whatever the matches and whatever `src_b_vld` is.
- R3: A source whose valid flag is low always selects the register file, code zero.
- R4: A stage matches a source only when that stage's write flag is high and its destination equals the source address.
- R5: `opnd_a` and `opnd_b` equal the data input named by their select code, in the same cycle.
- R6: `load_use` is high in the same cycle whenever a valid source matches a register-writing stage in M1 or M2 whose load flag is high.
- R7: `load_use` stays low for a load flag set without the write flag, and for a match that only writeback provides.
- R8: A writeback-selected operand held through a stall:
  - If `stall` is high in a cycle where an operand selects writeback and nothing is held, the writeback value is captured at that clock edge.
  - The operand then outputs the captured value in every following cycle up to and including the first cycle with `stall` low.
  - After that cycle it passes the selected value straight through again.
- R9: A synchronous reset (`rst` high at a clock edge) drops any held value. In the cycle after reset, the operands pass the selected data through.
- R10: A stall while an operand selects a source other than writeback captures nothing, and the operand keeps following its selected input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_vld | input | 1 | Operand A reads a register |
| src_a_addr | input | 3 | Operand A register number |
| src_b_vld | input | 1 | Operand B reads a register |
| src_b_addr | input | 3 | Operand B register number |
| use_imm | input | 1 | Operand B takes the immediate |
| m1_wr | input | 1 | M1 instruction writes a register |
| m1_load | input | 1 | M1 instruction is a load |
| m1_dst | input | 3 | M1 destination register |
| m2_wr | input | 1 | M2 instruction writes a register |
| m2_load | input | 1 | M2 instruction is a load |
| m2_dst | input | 3 | M2 destination register |
| wb_wr | input | 1 | Writeback instruction writes a register |
| wb_dst | input | 3 | Writeback destination register |
| rf_a_data | input | 16 | Register-file value for operand A |
| rf_b_data | input | 16 | Register-file value for operand B |
| imm_data | input | 16 | Immediate value |
| m1_data | input | 16 | M1 result |
| m2_data | input | 16 | M2 result |
| wb_data | input | 16 | Writeback result |
| stall | input | 1 | Pipeline stall in force |
| sel_a | output | 2 | Operand A source code |
| sel_b | output | 3 | Operand B source code |
| opnd_a | output | 16 | Operand A value |
| opnd_b | output | 16 | Operand B value |
| load_use | output | 1 | Load-use stall request |

## Verification
Select codes, operands and `load_use` are combinational, so a wrong match or a wrong priority shows at the ports in the same cycle its inputs are applied. The hold registers are the only state. A missed capture shows as a changed operand in the cycle after the stall edge. A hold that lasts too long shows one cycle after the stall is released, and a stale hold after reset shows in the first cycle after reset. The bench walks a vector table for the combinational cases and then runs directed stall and reset sequences, sampling in the cycle where each effect must appear.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_AW = 3;
    localparam int DATA_W = 16;
    localparam int SEL_A_W = 2;
    localparam int SEL_B_W = 3;
    localparam int N_OPND = 2;

    typedef logic [REG_AW-1:0] reg_addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        ORIG_RF,
        ORIG_IMM,
        ORIG_M1,
        ORIG_M2,
        ORIG_WB
    } origin_e;

    typedef struct packed {
        logic      wr;
        logic      load;
        reg_addr_t dst;
    } stage_t;

    typedef struct packed {
        logic      vld;
        reg_addr_t addr;
    } src_t;

    function automatic logic [SEL_A_W-1:0] enc_sel_a(origin_e o);
        case (o)
            ORIG_M1: return 2'b01;
            ORIG_M2: return 2'b10;
            ORIG_WB: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [SEL_B_W-1:0] enc_sel_b(origin_e o);
        case (o)
            ORIG_IMM: return 3'b001;
            ORIG_M1:  return 3'b010;
            ORIG_M2:  return 3'b011;
            ORIG_WB:  return 3'b100;
            default:  return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/fwd_src_resolve.sv
module fwd_src_resolve
    import fwd_pkg::*;
#(
    parameter bit ALLOW_IMM = 1'b0
) (
    input  src_t      src,
    input  logic      imm_sel,
    input  stage_t    m1,
    input  stage_t    m2,
    input  logic      wb_wr,
    input  reg_addr_t wb_dst,
    output origin_e   origin,
    output logic      lu_hazard
);

    logic hit_m1, hit_m2, hit_wb;

    always_comb begin
        hit_m1 = m1.wr && (m1.dst == src.addr);
        hit_m2 = m2.wr && (m2.dst == src.addr);
        hit_wb = wb_wr && (wb_dst == src.addr);

        origin = ORIG_RF;
        if (ALLOW_IMM && imm_sel) begin
            origin = ORIG_IMM;
        end else if (src.vld) begin
            if (hit_m1) begin
                origin = ORIG_M1;
            end else if (hit_m2) begin
                origin = ORIG_M2;
            end else if (hit_wb) begin
                origin = ORIG_WB;
            end
        end

        lu_hazard = src.vld && ((hit_m1 && m1.load) || (hit_m2 && m2.load));
    end

endmodule

// File: rtl/fwd_hold.sv
module fwd_hold
    import fwd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stall,
    input  logic  take,
    input  word_t d_i,
    output word_t d_o
);

    logic  held;
    word_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= 1'b0;
            hold_q <= '0;
        end else if (!stall) begin
            held <= 1'b0;
        end else if (!held && take) begin
            held   <= 1'b1;
            hold_q <= d_i;
        end
    end

    assign d_o = held ? hold_q : d_i;

    assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
        (stall && take && d_o == d_i) |=> (d_o == $past(d_i)));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        (!stall) |=> (d_o == d_i));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (d_o == d_i));

endmodule

// File: rtl/pipe_fwd_unit.sv
module pipe_fwd_unit
    import fwd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               src_a_vld,
    input  logic [REG_AW-1:0]  src_a_addr,
    input  logic               src_b_vld,
    input  logic [REG_AW-1:0]  src_b_addr,
    input  logic               use_imm,
    input  logic               m1_wr,
    input  logic               m1_load,
    input  logic [REG_AW-1:0]  m1_dst,
    input  logic               m2_wr,
    input  logic               m2_load,
    input  logic [REG_AW-1:0]  m2_dst,
    input  logic               wb_wr,
    input  logic [REG_AW-1:0]  wb_dst,
    input  logic [DATA_W-1:0]  rf_a_data,
    input  logic [DATA_W-1:0]  rf_b_data,
    input  logic [DATA_W-1:0]  imm_data,
    input  logic [DATA_W-1:0]  m1_data,
    input  logic [DATA_W-1:0]  m2_data,
    input  logic [DATA_W-1:0]  wb_data,
    input  logic               stall,
    output logic [SEL_A_W-1:0] sel_a,
    output logic [SEL_B_W-1:0] sel_b,
    output logic [DATA_W-1:0]  opnd_a,
    output logic [DATA_W-1:0]  opnd_b,
    output logic               load_use
);

    stage_t  st_m1, st_m2;
    src_t    srcs  [N_OPND];
    word_t   rf_val[N_OPND];
    logic    imm_in[N_OPND];
    origin_e org   [N_OPND];
    logic    lu    [N_OPND];
    word_t   raw   [N_OPND];
    word_t   fin   [N_OPND];

    assign st_m1 = '{wr: m1_wr, load: m1_load, dst: m1_dst};
    assign st_m2 = '{wr: m2_wr, load: m2_load, dst: m2_dst};

    assign srcs[0]   = '{vld: src_a_vld, addr: src_a_addr};
    assign srcs[1]   = '{vld: src_b_vld, addr: src_b_addr};
    assign rf_val[0] = rf_a_data;
    assign rf_val[1] = rf_b_data;
    assign imm_in[0] = 1'b0;
    assign imm_in[1] = use_imm;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fwd_src_resolve #(
            .ALLOW_IMM(g == 1)
        ) u_resolve (
            .src      (srcs[g]),
            .imm_sel  (imm_in[g]),
            .m1       (st_m1),
            .m2       (st_m2),
            .wb_wr    (wb_wr),
            .wb_dst   (wb_dst),
            .origin   (org[g]),
            .lu_hazard(lu[g])
        );

        always_comb begin
            case (org[g])
                ORIG_IMM: raw[g] = imm_data;
                ORIG_M1:  raw[g] = m1_data;
                ORIG_M2:  raw[g] = m2_data;
                ORIG_WB:  raw[g] = wb_data;
                default:  raw[g] = rf_val[g];
            endcase
        end

        fwd_hold u_hold (
            .clk  (clk),
            .rst  (rst),
            .stall(stall),
            .take (org[g] == ORIG_WB),
            .d_i  (raw[g]),
            .d_o  (fin[g])
        );
    end

    assign sel_a    = enc_sel_a(org[0]);
    assign sel_b    = enc_sel_b(org[1]);
    assign opnd_a   = fin[0];
    assign opnd_b   = fin[1];
    assign load_use = lu[0] || lu[1];

    assert_prio_m1_R1: assert property (@(posedge clk) disable iff (rst)
        (src_a_vld && m1_wr && src_a_addr == m1_dst) |-> (sel_a == 2'b01));

    assert_imm_wins_R2: assert property (@(posedge clk) disable iff (rst)
        use_imm |-> (sel_b == 3'b001));

    assert_invalid_rf_R3: assert property (@(posedge clk) disable iff (rst)
        (!src_a_vld) |-> (sel_a == 2'b00));

    assert_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (!m1_wr && !m2_wr && !wb_wr) |-> (sel_a == 2'b00));

    assert_load_m2_R6: assert property (@(posedge clk) disable iff (rst)
        (src_b_vld && m2_wr && m2_load && src_b_addr == m2_dst) |-> load_use);

    assert_no_lu_R7: assert property (@(posedge clk) disable iff (rst)
        (!(m1_wr && m1_load) && !(m2_wr && m2_load)) |-> !load_use);

endmodule

// File: tb/test_pipe_fwd_unit.sv
module test_pipe_fwd_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_a_vld = 1'b0, src_b_vld = 1'b0, use_imm = 1'b0;
    logic [2:0]  src_a_addr = '0, src_b_addr = '0;
    logic        m1_wr = 1'b0, m1_load = 1'b0, m2_wr = 1'b0, m2_load = 1'b0, wb_wr = 1'b0;
    logic [2:0]  m1_dst = '0, m2_dst = '0, wb_dst = '0;
    logic [15:0] rf_a_data = 16'h1111, rf_b_data = 16'h2222, imm_data = 16'h3333;
    logic [15:0] m1_data = 16'h4444, m2_data = 16'h5555, wb_data = 16'h6666;
    logic        stall = 1'b0;
    logic [1:0]  sel_a;
    logic [2:0]  sel_b;
    logic [15:0] opnd_a, opnd_b;
    logic        load_use;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pipe_fwd_unit i_pipe_fwd_unit (
        .clk(clk), .rst(rst),
        .src_a_vld(src_a_vld), .src_a_addr(src_a_addr),
        .src_b_vld(src_b_vld), .src_b_addr(src_b_addr), .use_imm(use_imm),
        .m1_wr(m1_wr), .m1_load(m1_load), .m1_dst(m1_dst),
        .m2_wr(m2_wr), .m2_load(m2_load), .m2_dst(m2_dst),
        .wb_wr(wb_wr), .wb_dst(wb_dst),
        .rf_a_data(rf_a_data), .rf_b_data(rf_b_data), .imm_data(imm_data),
        .m1_data(m1_data), .m2_data(m2_data), .wb_data(wb_data),
        .stall(stall), .sel_a(sel_a), .sel_b(sel_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .load_use(load_use)
    );

    typedef struct packed {
        logic       av; logic [2:0] aa;
        logic       bv; logic [2:0] ba;
        logic       imm;
        logic       m1w; logic m1l; logic [2:0] m1d;
        logic       m2w; logic m2l; logic [2:0] m2d;
        logic       wbw; logic [2:0] wbd;
        logic [1:0] ea; logic [2:0] eb; logic elu;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0,3'd0,1'b0,3'd0,1'b0, 1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,3'd0, 2'b00,3'b000,1'b0},
        '{1'b1,3'd2,1'b1,3'd5,1'b0, 1'b1,1'b0,3'd2, 1'b0,1'b0,3'd0, 1'b1,3'd5, 2'b01,3'b100,1'b0},
        '{1'b1,3'd3,1'b1,3'd3,1'b0, 1'b1,1'b0,3'd3, 1'b1,1'b0,3'd3, 1'b1,3'd3, 2'b01,3'b010,1'b0},
        '{1'b1,3'd4,1'b1,3'd4,1'b1, 1'b0,1'b0,3'd0, 1'b1,1'b0,3'd4, 1'b1,3'd4, 2'b10,3'b001,1'b0},
        '{1'b1,3'd6,1'b1,3'd6,1'b0, 1'b0,1'b1,3'd6, 1'b0,1'b0,3'd6, 1'b1,3'd6, 2'b11,3'b100,1'b0},
        '{1'b0,3'd1,1'b1,3'd1,1'b0, 1'b1,1'b1,3'd1, 1'b0,1'b0,3'd0, 1'b0,3'd0, 2'b00,3'b010,1'b1},
        '{1'b1,3'd7,1'b0,3'd7,1'b0, 1'b0,1'b0,3'd0, 1'b1,1'b1,3'd7, 1'b0,3'd0, 2'b10,3'b000,1'b1},
        '{1'b1,3'd0,1'b1,3'd2,1'b0, 1'b0,1'b0,3'd5, 1'b1,1'b0,3'd2, 1'b1,3'd0, 2'b11,3'b011,1'b0},
        '{1'b0,3'd0,1'b0,3'd1,1'b1, 1'b1,1'b1,3'd1, 1'b0,1'b0,3'd0, 1'b0,3'd0, 2'b00,3'b001,1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_a(input logic [1:0] c);
        case (c)
            2'b01:   return m1_data;
            2'b10:   return m2_data;
            2'b11:   return wb_data;
            default: return rf_a_data;
        endcase
    endfunction

    function automatic logic [15:0] exp_b(input logic [2:0] c);
        case (c)
            3'b001:  return imm_data;
            3'b010:  return m1_data;
            3'b011:  return m2_data;
            3'b100:  return wb_data;
            default: return rf_b_data;
        endcase
    endfunction

    task automatic apply(input vec_t v);
        src_a_vld = v.av; src_a_addr = v.aa;
        src_b_vld = v.bv; src_b_addr = v.ba; use_imm = v.imm;
        m1_wr = v.m1w; m1_load = v.m1l; m1_dst = v.m1d;
        m2_wr = v.m2w; m2_load = v.m2l; m2_dst = v.m2d;
        wb_wr = v.wbw; wb_dst = v.wbd;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        step();
        // reset state: nothing valid, register file passes through
        chk("R3 reset sel_a", {14'd0, sel_a}, 16'd0);
        chk("R3 reset sel_b", {13'd0, sel_b}, 16'd0);
        chk("R9 reset opnd_a", opnd_a, rf_a_data);
        chk("R6 reset load_use", {15'd0, load_use}, 16'd0);

        // table of combinational cases (R1 R2 R3 R4 R5 R6 R7)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            #1;
            chk($sformatf("R1 sel_a vec %0d", i), {14'd0, sel_a}, {14'd0, VEC[i].ea});
            chk($sformatf("R2 sel_b vec %0d", i), {13'd0, sel_b}, {13'd0, VEC[i].eb});
            chk($sformatf("R6 load_use vec %0d", i), {15'd0, load_use}, {15'd0, VEC[i].elu});
            chk($sformatf("R5 opnd_a vec %0d", i), opnd_a, exp_a(VEC[i].ea));
            chk($sformatf("R5 opnd_b vec %0d", i), opnd_b, exp_b(VEC[i].eb));
            step();
        end

        // R8: capture writeback value through a stall, on both operands
        apply(VEC[4]);
        wb_data = 16'hAAAA;
        stall = 1'b1;
        #1;
        chk("R8 pass in capture cycle", opnd_a, 16'hAAAA);
        step();
        wb_data = 16'hBBBB;
        #1;
        chk("R8 held a during stall", opnd_a, 16'hAAAA);
        chk("R8 held b during stall", opnd_b, 16'hAAAA);
        step();
        stall = 1'b0;
        #1;
        chk("R8 held in release cycle", opnd_a, 16'hAAAA);
        step();
        chk("R8 pass after release", opnd_a, 16'hBBBB);
        chk("R8 pass b after release", opnd_b, 16'hBBBB);

        // R10: stall while forwarding from M1 captures nothing
        apply(VEC[1]);
        m1_data = 16'hCCCC;
        stall = 1'b1;
        step();
        m1_data = 16'hDDDD;
        #1;
        chk("R10 no capture from M1", opnd_a, 16'hDDDD);
        stall = 1'b0;
        step();

        // R9: reset drops a held value
        apply(VEC[4]);
        wb_data = 16'h1234;
        stall = 1'b1;
        step();
        wb_data = 16'h5678;
        #1;
        chk("R8 held before reset", opnd_a, 16'h1234);
        rst = 1'b1;
        step();
        rst = 1'b0;
        #1;
        chk("R9 held value dropped", opnd_a, 16'h5678);
        chk("R9 held b dropped", opnd_b, 16'h5678);
        stall = 1'b0;
        step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule